// File: doc/BRIEF.md
# System Clock Source and Divider Control

This block holds the run-mode clock configuration word and turns it into the controls for the clock tree. The controls are: the oscillator source select, the oscillator disables, the crystal code, the PLL power-down and output-driver controls, and a path flag. The path flag reports whether the PLL clock is actually driving the system. The block also produces a clock-enable pulse train at the effective division ratio. Downstream logic uses that pulse train to qualify the root clock.

Software writes the whole 32-bit word in one bus cycle and can read it back at any time. When the configuration picks the PLL path (bypass cleared), the divider is always used. Codes below the minimum PLL code are raised to that minimum. The readback shows the raised code. The PLL is modelled only through its controls and a lock input. Until lock is reported with the PLL powered and driving, the path flag stays on the oscillator.

Top module: `sysclk_ctrl`

## Requirements
- R1: After reset the readback is 0x07803AC0. This means divisor code 0xF in bits 26:23, PLL power-down (bit 13), PLL output-driver-off (bit 12) and bypass (bit 11) all set, and crystal code 0xB in bits 9:6. Every other bit is 0.
- R2: Only bits 26:22, 13:11, 9:4 and 1:0 are writable, giving mask 0x07C03BF3. Writing 0xFFFFFFFF with bypass set reads back 0x07C03BF3. All other bits always read 0.
- R3: Bits 5:4 drive `osc_sel_o` with 00 = main oscillator, 01 = internal, 10 = internal/4 and 11 = reserved. Bit 1 drives `int_osc_off_o`, bit 0 drives `main_osc_off_o`, and bits 9:6 drive `xtal_sel_o`.
- R4: Bit 13 drives `pll_pwrdn_o` and bit 12 drives `pll_oe_off_o`.
- R5: `pll_path_o` is 1 only when bypass is 0, bit 13 is 0, bit 12 is 0 and `pll_lock_i` is 1. Otherwise the oscillator path is reported.
- R6: With bypass 1 and the use-divider bit (bit 22) at 0, `clk_en_o` is high on every cycle.
- R7: With bypass 1 and bit 22 at 1, `clk_en_o` pulses once every code+1 cycles. The reserved code 0 acts as /2.
- R8: With bypass 0, the divider is used even when bit 22 is 0.
- R9: With bypass 0, codes below 7 divide by 8. Codes of 7 and above divide by code+1.
- R10: With bypass 0, the divisor field reads back as the code actually in effect, so a written code below 7 reads back as 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Root clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the configuration word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Configuration readback |
| pll_lock_i | input | 1 | PLL lock status |
| osc_sel_o | output | 2 | Oscillator source select |
| main_osc_off_o | output | 1 | Main oscillator disable |
| int_osc_off_o | output | 1 | Internal oscillator disable |
| xtal_sel_o | output | 4 | Crystal frequency code |
| pll_pwrdn_o | output | 1 | PLL power-down |
| pll_oe_off_o | output | 1 | PLL output driver off |
| pll_path_o | output | 1 | PLL clock currently drives the system |
| clk_en_o | output | 1 | Divided clock-enable pulse |

## Verification
A corrupted configuration bit shows up on its control pin and on the readback on the cycle after the write. A wrong clamp or a wrong forced-divider decision changes the distance between two `clk_en_o` pulses. That change appears within one period of at most 16 cycles. The bench therefore measures pulse spacing after each reconfiguration and does not just look for pulses. A wrong lock qualification shows combinationally on `pll_path_o` as soon as the lock input or a control bit changes.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int DATA_W      = 32;
  localparam int DIV_W       = 4;
  localparam int DIV_LSB     = 23;
  localparam int USE_DIV_BIT = 22;
  localparam int PWRDN_BIT   = 13;
  localparam int OE_OFF_BIT  = 12;
  localparam int BYP_BIT     = 11;
  localparam int XTAL_LSB    = 6;
  localparam int OSC_LSB     = 4;
  localparam int IOFF_BIT    = 1;
  localparam int MOFF_BIT    = 0;

  localparam logic [DATA_W-1:0] WR_MASK =
      (((DATA_W)'(1) << DIV_W) - 1) << DIV_LSB
    | (DATA_W)'(1) << USE_DIV_BIT
    | (DATA_W)'(1) << PWRDN_BIT
    | (DATA_W)'(1) << OE_OFF_BIT
    | (DATA_W)'(1) << BYP_BIT
    | (DATA_W)'(32'hF) << XTAL_LSB
    | (DATA_W)'(32'h3) << OSC_LSB
    | (DATA_W)'(1) << IOFF_BIT
    | (DATA_W)'(1) << MOFF_BIT;

  typedef struct packed {
    logic [DIV_W-1:0] div_code;
    logic             use_div;
    logic             pwrdn;
    logic             oe_off;
    logic             bypass;
    logic [3:0]       xtal;
    logic [1:0]       osc_sel;
    logic             int_off;
    logic             main_off;
  } cfg_t;

  localparam cfg_t CFG_RST = '{
    div_code: '1, use_div: 1'b0, pwrdn: 1'b1, oe_off: 1'b1, bypass: 1'b1,
    xtal: 4'hB, osc_sel: 2'b00, int_off: 1'b0, main_off: 1'b0};
endpackage

// File: rtl/sysclk_cfg_reg.sv
module sysclk_cfg_reg
  import sysclk_pkg::*;
#(
  parameter int MIN_PLL_CODE = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DIV_W-1:0]  rb_code_i,
  output cfg_t              cfg_o,
  output logic [DATA_W-1:0] rdata_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
    end else if (wr_en_i) begin
      cfg_q.div_code <= wdata_i[DIV_LSB +: DIV_W];
      cfg_q.use_div  <= wdata_i[USE_DIV_BIT];
      cfg_q.pwrdn    <= wdata_i[PWRDN_BIT];
      cfg_q.oe_off   <= wdata_i[OE_OFF_BIT];
      cfg_q.bypass   <= wdata_i[BYP_BIT];
      cfg_q.xtal     <= wdata_i[XTAL_LSB +: 4];
      cfg_q.osc_sel  <= wdata_i[OSC_LSB +: 2];
      cfg_q.int_off  <= wdata_i[IOFF_BIT];
      cfg_q.main_off <= wdata_i[MOFF_BIT];
    end
  end

  always_comb begin
    rdata_o                       = '0;
    rdata_o[DIV_LSB +: DIV_W]     = rb_code_i;
    rdata_o[USE_DIV_BIT]          = cfg_q.use_div;
    rdata_o[PWRDN_BIT]            = cfg_q.pwrdn;
    rdata_o[OE_OFF_BIT]           = cfg_q.oe_off;
    rdata_o[BYP_BIT]              = cfg_q.bypass;
    rdata_o[XTAL_LSB +: 4]        = cfg_q.xtal;
    rdata_o[OSC_LSB +: 2]         = cfg_q.osc_sel;
    rdata_o[IOFF_BIT]             = cfg_q.int_off;
    rdata_o[MOFF_BIT]             = cfg_q.main_off;
  end

  assign cfg_o = cfg_q;

  AST_RSVD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ((wdata_i & ~WR_MASK) != '0)) |=> ((rdata_o & ~WR_MASK) == '0)); // R2
  AST_HOLD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cfg_q)); // R2
  AST_CLAMP_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q.bypass |-> (rdata_o[DIV_LSB +: DIV_W] >= DIV_W'(MIN_PLL_CODE))); // R10
endmodule

// File: rtl/sysclk_path_sel.sv
module sysclk_path_sel
  import sysclk_pkg::*;
#(
  parameter int MIN_PLL_CODE = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cfg_t             cfg_i,
  input  logic             pll_lock_i,
  output logic             pll_path_o,
  output logic [DIV_W-1:0] ratio_m1_o,
  output logic [DIV_W-1:0] rb_code_o
);
  localparam logic [DIV_W-1:0] MIN_CODE = DIV_W'(MIN_PLL_CODE);

  logic             pll_sel;
  logic [DIV_W-1:0] clamp_code;

  assign pll_sel    = !cfg_i.bypass;
  assign clamp_code = (cfg_i.div_code < MIN_CODE) ? MIN_CODE : cfg_i.div_code;
  assign rb_code_o  = pll_sel ? clamp_code : cfg_i.div_code;

  // PLL path forces the divider; reserved code 0 acts as /2 on the direct path
  always_comb begin
    if (pll_sel)                  ratio_m1_o = clamp_code;
    else if (!cfg_i.use_div)      ratio_m1_o = '0;
    else if (cfg_i.div_code == '0) ratio_m1_o = DIV_W'(1);
    else                          ratio_m1_o = cfg_i.div_code;
  end

  // stay on oscillator until PLL is powered, driving and locked
  assign pll_path_o = pll_sel && !cfg_i.pwrdn && !cfg_i.oe_off && pll_lock_i;

  AST_PLL_MIN_RATIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.bypass |-> (ratio_m1_o >= MIN_CODE)); // R9
  AST_PLL_NEEDS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll_lock_i |-> !pll_path_o); // R5
endmodule

// File: rtl/sysclk_en_div.sv
module sysclk_en_div
  import sysclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] ratio_m1_i,
  output logic             clk_en_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (cnt_q >= ratio_m1_i) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  assign clk_en_o = (cnt_q == ratio_m1_i);

  AST_BACK_TO_BACK_ONLY_UNDIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o && $past(clk_en_o) && $stable(ratio_m1_i)) |-> (ratio_m1_i == '0)); // R6
  AST_WRAP_AFTER_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
  import sysclk_pkg::*;
#(
  parameter int MIN_PLL_CODE = 7
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        pll_lock_i,
  output logic [1:0]  osc_sel_o,
  output logic        main_osc_off_o,
  output logic        int_osc_off_o,
  output logic [3:0]  xtal_sel_o,
  output logic        pll_pwrdn_o,
  output logic        pll_oe_off_o,
  output logic        pll_path_o,
  output logic        clk_en_o
);
  cfg_t             cfg;
  logic [DIV_W-1:0] rb_code;
  logic [DIV_W-1:0] ratio_m1;

  sysclk_cfg_reg #(.MIN_PLL_CODE(MIN_PLL_CODE)) i_cfg_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wdata_i   (wdata_i),
    .rb_code_i (rb_code),
    .cfg_o     (cfg),
    .rdata_o   (rdata_o)
  );

  sysclk_path_sel #(.MIN_PLL_CODE(MIN_PLL_CODE)) i_path_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_i      (cfg),
    .pll_lock_i (pll_lock_i),
    .pll_path_o (pll_path_o),
    .ratio_m1_o (ratio_m1),
    .rb_code_o  (rb_code)
  );

  sysclk_en_div i_en_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ratio_m1_i (ratio_m1),
    .clk_en_o   (clk_en_o)
  );

  assign osc_sel_o      = cfg.osc_sel;
  assign main_osc_off_o = cfg.main_off;
  assign int_osc_off_o  = cfg.int_off;
  assign xtal_sel_o     = cfg.xtal;
  assign pll_pwrdn_o    = cfg.pwrdn;
  assign pll_oe_off_o   = cfg.oe_off;

  AST_PWRDN_BLOCKS_PLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_pwrdn_o |-> !pll_path_o); // R5
  AST_BYPASS_BLOCKS_PLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[BYP_BIT] |-> !pll_path_o); // R5
endmodule

// File: tb/test_sysclk_ctrl.sv
module test_sysclk_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        pll_lock_i = 1'b0;
  logic [1:0]  osc_sel_o;
  logic        main_osc_off_o, int_osc_off_o;
  logic [3:0]  xtal_sel_o;
  logic        pll_pwrdn_o, pll_oe_off_o, pll_path_o, clk_en_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sysclk_ctrl i_sysclk_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .pll_lock_i(pll_lock_i), .osc_sel_o(osc_sel_o),
    .main_osc_off_o(main_osc_off_o), .int_osc_off_o(int_osc_off_o),
    .xtal_sel_o(xtal_sel_o), .pll_pwrdn_o(pll_pwrdn_o),
    .pll_oe_off_o(pll_oe_off_o), .pll_path_o(pll_path_o), .clk_en_o(clk_en_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops expected readbacks and compares
  always @(negedge clk_i) begin
    #1;
    if (exp_q.size() > 0) chk(rdata_o, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1;
    wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic expect_rb(input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk_i);
    #2;
  endtask

  task automatic wait_pulse();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      #1;
      if (clk_en_o) return;
    end
  endtask

  task automatic period(input int exp, input string tag);
    int n;
    wait_pulse();
    wait_pulse();
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      #1;
      n++;
      if (clk_en_o) break;
    end
    chk(32'(n), 32'(exp), tag);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    expect_rb(32'h07803AC0, "R1 reset readback");
    chk(32'(pll_pwrdn_o), 1, "R4 reset power-down");
    chk(32'(pll_oe_off_o), 1, "R4 reset driver off");
    chk(32'(xtal_sel_o), 32'hB, "R1 reset crystal");
    chk(32'(pll_path_o), 0, "R5 reset path");
    period(1, "R6 reset undivided");

    // R2 reserved bits ignored
    wr(32'hFFFFFFFF);
    expect_rb(32'h07C03BF3, "R2 reserved read zero");
    chk(32'(osc_sel_o), 3, "R3 osc select all ones");
    chk(32'(main_osc_off_o), 1, "R3 main off");
    period(16, "R7 code F direct");

    // R3 oscillator fields
    wr(32'h00000822);
    expect_rb(32'h00000822, "R3 readback");
    chk(32'(osc_sel_o), 2, "R3 internal/4 select");
    chk(32'(int_osc_off_o), 1, "R3 internal off");
    chk(32'(main_osc_off_o), 0, "R3 main on");
    chk(32'(xtal_sel_o), 0, "R3 crystal code");

    // R7 direct path divider
    wr(32'h01400800);
    expect_rb(32'h01400800, "R7 readback code 2");
    period(3, "R7 code 2 direct");
    wr(32'h00400800);
    expect_rb(32'h00400800, "R7 readback code 0");
    period(2, "R7 code 0 acts as /2");

    // R6 divider unused
    wr(32'h01000800);
    period(1, "R6 use-div clear");

    // R8 R9 R10 PLL path, code 2
    wr(32'h01000000);
    expect_rb(32'h03800000, "R10 clamped readback");
    chk(32'(pll_pwrdn_o), 0, "R4 power-down clear");
    chk(32'(pll_oe_off_o), 0, "R4 driver on");
    chk(32'(pll_path_o), 0, "R5 no lock stays on oscillator");
    period(8, "R8 forced divider clamped to /8");
    @(negedge clk_i);
    pll_lock_i = 1'b1;
    #1;
    chk(32'(pll_path_o), 1, "R5 locked PLL path");

    wr(32'h05000000);
    expect_rb(32'h05000000, "R10 code above minimum");
    period(11, "R9 code A on PLL path");

    wr(32'h07C00000);
    period(16, "R8 code F on PLL path");

    wr(32'h01002000);
    expect_rb(32'h03802000, "R10 clamp with power-down");
    chk(32'(pll_path_o), 0, "R5 power-down blocks PLL");
    wr(32'h01001000);
    chk(32'(pll_path_o), 0, "R5 driver off blocks PLL");

    repeat (3) @(negedge clk_i);
    summary();
  end
endmodule